// File: doc/BRIEF.md
# Fetch Queue Prefetch Filter

This block sits between a decoupled branch predictor and the instruction fetch stage. It keeps a circular queue of predicted fetch blocks. Each entry holds up to three instruction-cache lines, and each line has its own valid flag and a flag that records whether the line has already been sent for prefetch. Each entry also holds the target address of the branch that closes the block. The predictor's fetch-target lookup writes entries at the tail. The fetch stage reads the oldest entry at the head and releases it when it is done.

Every cycle a filter scans a window of the queue and copies line addresses that have not been handled yet into a small prefetch queue. The window runs from the entry just behind the head to the tenth entry, so the head itself is never scanned, because it is about to be fetched anyway. A prefetch engine takes addresses from the prefetch queue one at a time. It does so only when the L2 bus is idle and a prefetch buffer is free. A misprediction flush empties both queues in one cycle.

Top module: `fetch_prefetch_filter`

## Requirements
- R1: After reset, `head_valid` and `pf_valid` are 0, `enq_ready` is 1 and `pf_issue` is 0.
- R2: The fetch queue is first-in first-out. The head outputs show the oldest entry. Line j of an entry is `enq_line[j*26 +: 26]` with valid bit `enq_blk_vld[j]`. `deq` releases the head. When 16 entries are held, `enq_ready` is 0 and an enqueue request is dropped.
- R3: Lines of the head entry (offset 0 from the head) are never moved into the prefetch queue while they sit at the head.
- R4: Only entries at offsets 1 through 9 from the head are scanned. An entry at offset 10 or beyond contributes no line until dequeues bring it into that window.
- R5: Only lines that are valid and not yet marked are eligible. Moving a line marks it, so each line is issued at most once.
- R6: At most 3 lines move per cycle. They are chosen from the oldest entry first, and in line order 0, 1, 2 within an entry. Lines from an entry enqueued at clock edge k move at edge k+1 when room allows.
- R7: The number of lines moved is also limited by the free slots of the 8-deep prefetch queue, counted at the start of the cycle. Lines that do not fit stay unmarked and move in later cycles, in the same order.
- R8: `pf_issue` is 1 exactly when `pf_valid`, `l2_idle` and `pbuf_free` are all 1 and `flush` is 0. `pf_line_addr` is the oldest queued line, and it is removed at that edge.
- R9: A `flush` cycle issues nothing. After that edge both queues are empty (`head_valid`=0, `pf_valid`=0, `enq_ready`=1), and the block works normally for entries enqueued afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Misprediction flush of both queues |
| enq_valid | input | 1 | Enqueue request from the fetch-target lookup |
| enq_ready | output | 1 | Fetch queue has a free entry |
| enq_blk_vld | input | 3 | Valid flag per line of the new entry |
| enq_line | input | 78 | Three 26-bit line addresses, line 0 in the low bits |
| enq_target | input | 32 | Target of the branch closing the block |
| deq | input | 1 | Fetch stage releases the head entry |
| head_valid | output | 1 | Head entry present |
| head_blk_vld | output | 3 | Valid flags of the head entry's lines |
| head_line | output | 78 | Line addresses of the head entry |
| head_target | output | 32 | Branch target of the head entry |
| l2_idle | input | 1 | L2 bus free for a prefetch |
| pbuf_free | input | 1 | A prefetch buffer slot is free |
| pf_valid | output | 1 | Prefetch queue not empty |
| pf_issue | output | 1 | Prefetch address taken this cycle |
| pf_line_addr | output | 26 | Oldest queued prefetch line address |

## Verification
The bench places the only valid lines at the head, or at offset 10, and watches that no prefetch appears. A filter that scans the head or misses the window boundary would issue those lines early. It over-fills the prefetch queue while the L2 is busy and then checks that every leftover line still comes out once and in order. A design that dropped or re-marked lines there would lose or duplicate addresses. It drives issue conditions one at a time, and flushes while lines are pending, so that any stale line issued after the flush shows up as a miscompare. It also fills the fetch queue and dequeues all of it to show that an enqueue at full is dropped.

// File: rtl/fqpf_pkg.sv
// Shared widths and storage types of the fetch queue prefetch filter.
// Assumes 26-bit line addresses and three lines per fetch block.
package fqpf_pkg;
    localparam int LINE_W = 26;
    localparam int SUBS   = 3;
    localparam int TGT_W  = 32;

    typedef struct packed {
        logic              vld;
        logic              queued;
        logic [LINE_W-1:0] line;
    } blk_t;

    typedef struct packed {
        blk_t [SUBS-1:0]  blk;
        logic [TGT_W-1:0] target;
    } slot_t;
endpackage

// File: rtl/fqpf_ftq.sv
// Circular fetch target queue. Entries are written at the tail and released
// at the head. The per-line queued flags are set from the mark matrix.
// Assumes DEPTH is a power of two and that marks name only lines inside the queue.
module fqpf_ftq
    import fqpf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        enq_valid,
    input  logic [SUBS-1:0]             enq_vld,
    input  logic [SUBS*LINE_W-1:0]      enq_line,
    input  logic [TGT_W-1:0]            enq_target,
    input  logic                        deq,
    input  logic [DEPTH-1:0][SUBS-1:0]  mark,
    output slot_t                       slots [DEPTH],
    output logic [PW-1:0]               head_ptr,
    output logic [CW-1:0]               occupancy,
    output logic                        full
);
    slot_t                       mem_q [DEPTH];
    logic [PW-1:0]               head_q, tail_q;
    logic [CW-1:0]               cnt_q;
    slot_t                       new_slot;
    logic                        do_enq, do_deq;
    logic [DEPTH-1:0][SUBS-1:0]  open_blk;

    assign full      = (cnt_q == CW'(DEPTH));
    assign do_enq    = enq_valid && !full;
    assign do_deq    = deq && (cnt_q != '0);
    assign slots     = mem_q;
    assign head_ptr  = head_q;
    assign occupancy = cnt_q;

    // Build the incoming entry with every queued flag clear.
    always_comb begin
        new_slot.target = enq_target;
        for (int j = 0; j < SUBS; j++) begin
            new_slot.blk[j].vld    = enq_vld[j];
            new_slot.blk[j].queued = 1'b0;
            new_slot.blk[j].line   = enq_line[j*LINE_W +: LINE_W];
        end
    end

    // Pointer, count and storage update; reset and flush empty the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++)
                for (int j = 0; j < SUBS; j++)
                    if (mark[i][j]) mem_q[i].blk[j].queued <= 1'b1;
            if (do_enq) begin
                mem_q[tail_q] <= new_slot;
                tail_q        <= tail_q + 1'b1;
            end
            if (do_deq) head_q <= head_q + 1'b1;
            cnt_q <= cnt_q + CW'(do_enq) - CW'(do_deq);
        end
    end

    // Lines still open for selection, used only by the checks below.
    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            for (int j = 0; j < SUBS; j++)
                open_blk[i][j] = mem_q[i].blk[j].vld && !mem_q[i].blk[j].queued;
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    // R3
    head_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mark[head_q] == '0);
    // R5
    mark_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mark & ~open_blk) == '0);
    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt_q == '0));
endmodule

// File: rtl/fqpf_scan.sv
// Prefetch filter. It scans queue offsets WIN_FIRST..WIN_LAST from the head and
// picks open lines oldest entry first, line 0 first. The number picked is capped
// by PICK_MAX and by the free room in the prefetch queue.
// Assumes WIN_LAST < DEPTH.
module fqpf_scan
    import fqpf_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int WIN_FIRST = 1,
    parameter int WIN_LAST  = 9,
    parameter int PICK_MAX  = 3,
    parameter int ROOM_W    = 4,
    parameter int PW        = $clog2(DEPTH),
    parameter int CW        = $clog2(DEPTH + 1),
    parameter int PNW       = $clog2(PICK_MAX + 1)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  slot_t                              slots [DEPTH],
    input  logic [PW-1:0]                      head_ptr,
    input  logic [CW-1:0]                      occupancy,
    input  logic [ROOM_W-1:0]                  room,
    output logic [DEPTH-1:0][SUBS-1:0]         mark,
    output logic [PNW-1:0]                     pick_n,
    output logic [PICK_MAX-1:0][LINE_W-1:0]    pick_line
);
    localparam int WIN = WIN_LAST - WIN_FIRST + 1;

    logic [PW-1:0]  pos_idx [WIN];
    logic [WIN-1:0] pos_live;
    logic [PNW-1:0] cap;
    logic [PNW-1:0] taken;

    // Map each window position to a physical slot and check it holds an entry.
    for (genvar k = 0; k < WIN; k++) begin : g_pos
        assign pos_idx[k]  = head_ptr + PW'(WIN_FIRST + k);
        assign pos_live[k] = occupancy > CW'(WIN_FIRST + k);
    end

    // Per-cycle budget: the smaller of the pick limit and the free room.
    always_comb begin
        if (room >= ROOM_W'(PICK_MAX)) cap = PNW'(PICK_MAX);
        else                           cap = PNW'(room);
    end

    // Priority walk over the window in age order, then line order.
    always_comb begin
        mark      = '0;
        pick_line = '0;
        taken     = '0;
        for (int k = 0; k < WIN; k++) begin
            for (int j = 0; j < SUBS; j++) begin
                if (pos_live[k] && slots[pos_idx[k]].blk[j].vld &&
                    !slots[pos_idx[k]].blk[j].queued && (taken < cap)) begin
                    mark[pos_idx[k]][j] = 1'b1;
                    pick_line[taken]    = slots[pos_idx[k]].blk[j].line;
                    taken               = taken + 1'b1;
                end
            end
        end
        pick_n = taken;
    end

    // R6
    pick_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mark) <= PICK_MAX);
    // R7
    room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ROOM_W'(pick_n) <= room);
endmodule

// File: rtl/fqpf_piq.sv
// Prefetch instruction queue. It accepts up to PICK_MAX line addresses per
// cycle, pops one per cycle and reports its free room.
// Assumes DEPTH is a power of two and that the caller never pushes beyond room.
module fqpf_piq
    import fqpf_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int PICK_MAX = 3,
    parameter int AW       = $clog2(DEPTH),
    parameter int CW       = $clog2(DEPTH + 1),
    parameter int PNW      = $clog2(PICK_MAX + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             flush,
    input  logic [PNW-1:0]                   push_n,
    input  logic [PICK_MAX-1:0][LINE_W-1:0]  push_line,
    input  logic                             pop,
    output logic                             nonempty,
    output logic [LINE_W-1:0]                head_line,
    output logic [CW-1:0]                    room
);
    logic [LINE_W-1:0] mem_q [DEPTH];
    logic [AW-1:0]     rd_q, wr_q;
    logic [CW-1:0]     cnt_q;
    logic              do_pop;

    assign nonempty  = (cnt_q != '0);
    assign do_pop    = pop && nonempty;
    assign room      = CW'(DEPTH) - cnt_q;
    assign head_line = nonempty ? mem_q[rd_q] : '0;

    // Multi-write at the tail, single read at the head.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            for (int p = 0; p < PICK_MAX; p++)
                if (PNW'(p) < push_n) mem_q[wr_q + AW'(p)] <= push_line[p];
            wr_q <= wr_q + AW'(push_n);
            if (do_pop) rd_q <= rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(push_n) - CW'(do_pop);
        end
    end

    // R7
    piq_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    // R8
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0));
endmodule

// File: rtl/fetch_prefetch_filter.sv
// Top of the fetch queue prefetch filter. It joins the fetch target queue, the
// window filter and the prefetch queue, and gates prefetch issue on L2 and
// buffer availability. A flush has priority over all other activity in its cycle.
module fetch_prefetch_filter
    import fqpf_pkg::*;
#(
    parameter int FTQ_DEPTH = 16,
    parameter int PIQ_DEPTH = 8,
    parameter int WIN_FIRST = 1,
    parameter int WIN_LAST  = 9,
    parameter int PICK_MAX  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    enq_valid,
    output logic                    enq_ready,
    input  logic [SUBS-1:0]         enq_blk_vld,
    input  logic [SUBS*LINE_W-1:0]  enq_line,
    input  logic [TGT_W-1:0]        enq_target,
    input  logic                    deq,
    output logic                    head_valid,
    output logic [SUBS-1:0]         head_blk_vld,
    output logic [SUBS*LINE_W-1:0]  head_line,
    output logic [TGT_W-1:0]        head_target,
    input  logic                    l2_idle,
    input  logic                    pbuf_free,
    output logic                    pf_valid,
    output logic                    pf_issue,
    output logic [LINE_W-1:0]       pf_line_addr
);
    localparam int PW  = $clog2(FTQ_DEPTH);
    localparam int CW  = $clog2(FTQ_DEPTH + 1);
    localparam int RW  = $clog2(PIQ_DEPTH + 1);
    localparam int PNW = $clog2(PICK_MAX + 1);

    slot_t                           slots [FTQ_DEPTH];
    slot_t                           head_slot;
    logic [PW-1:0]                   head_ptr;
    logic [CW-1:0]                   occupancy;
    logic                            ftq_full;
    logic [FTQ_DEPTH-1:0][SUBS-1:0]  mark;
    logic [PNW-1:0]                  pick_n;
    logic [PICK_MAX-1:0][LINE_W-1:0] pick_line;
    logic [RW-1:0]                   room;

    fqpf_ftq #(.DEPTH(FTQ_DEPTH)) u_ftq (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .enq_valid  (enq_valid),
        .enq_vld    (enq_blk_vld),
        .enq_line   (enq_line),
        .enq_target (enq_target),
        .deq        (deq),
        .mark       (mark),
        .slots      (slots),
        .head_ptr   (head_ptr),
        .occupancy  (occupancy),
        .full       (ftq_full)
    );

    fqpf_scan #(
        .DEPTH     (FTQ_DEPTH),
        .WIN_FIRST (WIN_FIRST),
        .WIN_LAST  (WIN_LAST),
        .PICK_MAX  (PICK_MAX),
        .ROOM_W    (RW)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .slots     (slots),
        .head_ptr  (head_ptr),
        .occupancy (occupancy),
        .room      (room),
        .mark      (mark),
        .pick_n    (pick_n),
        .pick_line (pick_line)
    );

    fqpf_piq #(.DEPTH(PIQ_DEPTH), .PICK_MAX(PICK_MAX)) u_piq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push_n    (pick_n),
        .push_line (pick_line),
        .pop       (pf_issue),
        .nonempty  (pf_valid),
        .head_line (pf_line_addr),
        .room      (room)
    );

    // Head entry presentation to the fetch stage.
    always_comb begin
        head_slot   = slots[head_ptr];
        head_valid  = (occupancy != '0);
        head_target = head_slot.target;
        for (int j = 0; j < SUBS; j++) begin
            head_blk_vld[j]                 = head_valid && head_slot.blk[j].vld;
            head_line[j*LINE_W +: LINE_W]   = head_slot.blk[j].line;
        end
    end

    assign enq_ready = !ftq_full;
    assign pf_issue  = pf_valid && l2_idle && pbuf_free && !flush;

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!pf_valid && !head_valid));
endmodule

// File: tb/fetch_prefetch_filter_test.sv
module fetch_prefetch_filter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, flush, enq_valid, enq_ready, deq;
    logic [2:0]  enq_blk_vld, head_blk_vld;
    logic [77:0] enq_line, head_line;
    logic [31:0] enq_target, head_target;
    logic        head_valid, l2_idle, pbuf_free, pf_valid, pf_issue;
    logic [25:0] pf_line_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [25:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_prefetch_filter uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_blk_vld(enq_blk_vld),
        .enq_line(enq_line), .enq_target(enq_target), .deq(deq),
        .head_valid(head_valid), .head_blk_vld(head_blk_vld), .head_line(head_line),
        .head_target(head_target), .l2_idle(l2_idle), .pbuf_free(pbuf_free),
        .pf_valid(pf_valid), .pf_issue(pf_issue), .pf_line_addr(pf_line_addr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic want(input logic [25:0] line);
        exp_q.push_back(line);
    endtask

    // Enqueue one entry; line j gets address base+j.
    task automatic put(input logic [2:0] v, input logic [25:0] base, input logic [31:0] tgt);
        enq_valid   = 1'b1;
        enq_blk_vld = v;
        enq_line    = {base + 26'd2, base + 26'd1, base};
        enq_target  = tgt;
        cyc();
        enq_valid   = 1'b0;
    endtask

    // Scoreboard monitor: every issued line must be the next expected one.
    always @(negedge clk) begin
        if (rst_n && pf_issue) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R5 unexpected issue actual=%0h expected=none", pf_line_addr);
            end else begin
                logic [25:0] e;
                e = exp_q.pop_front();
                if (pf_line_addr !== e) begin
                    n_fail++;
                    $display("FAIL R6 issue order actual=%0h expected=%0h", pf_line_addr, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [25:0] bases [16];
        rst_n = 1'b0; flush = 1'b0; enq_valid = 1'b0; deq = 1'b0;
        enq_blk_vld = '0; enq_line = '0; enq_target = '0;
        l2_idle = 1'b0; pbuf_free = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1 reset state
        chk("R1 head_valid", head_valid, 0);
        chk("R1 pf_valid", pf_valid, 0);
        chk("R1 enq_ready", enq_ready, 1);
        chk("R1 pf_issue", pf_issue, 0);

        // R2 head contents, R3 head never prefetched
        l2_idle = 1'b1; pbuf_free = 1'b1;
        put(3'b111, 26'h100, 32'hCAFE_0000);
        chk("R2 head_valid", head_valid, 1);
        chk("R2 head_blk_vld", head_blk_vld, 3'b111);
        chk("R2 head_line", head_line, {26'h102, 26'h101, 26'h100});
        chk("R2 head_target", head_target, 32'hCAFE_0000);
        repeat (4) cyc();
        chk("R3 head lines not queued", pf_valid, 0);

        // R5/R6 eligibility and order
        want(26'h200); want(26'h202);
        put(3'b101, 26'h200, 32'h1);
        want(26'h300); want(26'h301); want(26'h302);
        put(3'b111, 26'h300, 32'h2);
        want(26'h401);
        put(3'b010, 26'h400, 32'h3);
        repeat (12) cyc();
        chk("R6 all lines issued in order", exp_q.size(), 0);

        // R8 issue gating
        l2_idle = 1'b0;
        want(26'h500);
        put(3'b001, 26'h500, 32'h4);
        repeat (2) cyc();
        chk("R8 pf_valid", pf_valid, 1);
        chk("R8 pf_line_addr", pf_line_addr, 26'h500);
        chk("R8 blocked by l2", pf_issue, 0);
        l2_idle = 1'b1; pbuf_free = 1'b0; #1;
        chk("R8 blocked by buffer", pf_issue, 0);
        pbuf_free = 1'b1; #1;
        chk("R8 issue when both free", pf_issue, 1);
        cyc();
        chk("R8 popped", pf_valid, 0);

        // R7 room limit and leftovers
        l2_idle = 1'b0;
        for (int e = 0; e < 4; e++) begin
            for (int j = 0; j < 3; j++) want(26'h600 + 26'(e) * 26'h100 + 26'(j));
            put(3'b111, 26'h600 + 26'(e) * 26'h100, 32'(e));
        end
        repeat (3) cyc();
        chk("R7 queue full head", pf_line_addr, 26'h600);
        l2_idle = 1'b1;
        repeat (20) cyc();
        chk("R7 leftovers issued later", exp_q.size(), 0);

        // R4 window boundary: entry at offset 10 is not scanned
        put(3'b000, 26'hA00, 32'h9);
        put(3'b111, 26'hB00, 32'hA);
        repeat (4) cyc();
        chk("R4 offset 10 not scanned", pf_valid, 0);
        want(26'hB00); want(26'hB01); want(26'hB02);
        deq = 1'b1; cyc(); deq = 1'b0;
        chk("R2 head after deq", head_line[25:0], 26'h200);
        chk("R2 head vld after deq", head_blk_vld, 3'b101);
        repeat (6) cyc();
        chk("R4 entered window issued", exp_q.size(), 0);

        // R2 full queue and drop at full
        for (int i = 0; i < 6; i++) put(3'b000, 26'hC00 + 26'(i) * 26'h10, 32'h0);
        chk("R2 enq_ready at full", enq_ready, 0);
        put(3'b111, 26'hF00, 32'h0);
        bases[0] = 26'h200; bases[1] = 26'h300; bases[2] = 26'h400; bases[3] = 26'h500;
        bases[4] = 26'h600; bases[5] = 26'h700; bases[6] = 26'h800; bases[7] = 26'h900;
        bases[8] = 26'hA00; bases[9] = 26'hB00;
        for (int i = 0; i < 6; i++) bases[10+i] = 26'hC00 + 26'(i) * 26'h10;
        for (int i = 0; i < 16; i++) begin
            chk("R2 fifo order", head_line[25:0], bases[i]);
            deq = 1'b1; cyc(); deq = 1'b0;
        end
        chk("R2 dropped entry absent", head_valid, 0);

        // R9 flush
        l2_idle = 1'b0;
        put(3'b111, 26'hD00, 32'h0);
        put(3'b111, 26'hE00, 32'h0);
        repeat (2) cyc();
        chk("R9 pending before flush", pf_valid, 1);
        flush = 1'b1; l2_idle = 1'b1; #1;
        chk("R9 no issue in flush cycle", pf_issue, 0);
        cyc();
        flush = 1'b0;
        chk("R9 fetch queue empty", head_valid, 0);
        chk("R9 prefetch queue empty", pf_valid, 0);
        chk("R9 enq_ready", enq_ready, 1);
        repeat (4) cyc();
        put(3'b111, 26'h1000, 32'h0);
        want(26'h1100); want(26'h1101);
        put(3'b011, 26'h1100, 32'h0);
        repeat (8) cyc();
        chk("R9 normal after flush", exp_q.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule